// File: doc/BRIEF.md
# Time-Triggered Bank-Group DRAM Scheduler

This block drives a DDR-style command bus for a device that is split into four private bank groups, one per requester (for example one per hardware thread). Group g sits in rank g%2 and uses bank g/2. Time is cut into slots of `SLOT_CYC` cycles. The slots are handed to the groups in the fixed order 0, 1, 2, 3, 0, ... whether or not any requester has work. Each slot serves at most one closed-page access. The access opens its row with an activate command, and the column command carries auto-precharge. Because of this, the timing of an access never depends on which row was open before, or on what the other requesters are doing.

Each requester has a valid/ready request port carrying the direction, the row and the column. The back-pressure rules are strict. `req_ready[g]` is high for exactly one cycle, the first cycle of group g's slot, and it does not depend on `req_valid`. A request is taken only when valid and ready are high together in that cycle. A requester that is not ready at that point keeps its request, or withdraws it, and waits for its next slot four slots later. The slot is never lent to another group. Completion is reported by a one-cycle `done[g]` pulse a fixed `DONE_LAT` cycles after the column command. Refresh, the data path and address decoding belong to other blocks.

Top module: `tt_bank_sched`

## Requirements
- R1: While reset is held, and in the first cycle after its release, the command bus shows NOP (cmd 2'b00) with rank, bank, address and auto-precharge all zero. In that first cycle `req_ready` equals 4'b0001, which places the rotation at group 0.
- R2: `req_ready` is one-hot for one cycle every `SLOT_CYC` cycles and zero otherwise. Its set bit steps 0,1,2,3,0,... whatever the request inputs are.
- R3: A request taken from group g in the first cycle of its slot puts ACT (cmd 2'b01) on the bus in the next cycle, with rank = g%2, bank = g/2, address = row (zero-extended) and auto-precharge low.
- R4: Exactly `T_RCD` cycles after that ACT, the bus carries RD (2'b10) for a read (we=0) or WR (2'b11) for a write (we=1). This command has address = column, auto-precharge high, and the same rank and bank as the ACT.
- R5: In every cycle that carries neither of the commands of R3 and R4, the bus shows NOP with rank, bank, address and auto-precharge at zero.
- R6: If group g's valid is low in its ready cycle, its whole slot is NOPs. Valid inputs of other groups, and valid in non-ready cycles, have no effect.
- R7: `done[g]` pulses high for one cycle exactly `DONE_LAT` cycles after each column command of group g, and at most one done bit is high at a time.
- R8: The delay from a taken request to its `done` is always 1+`T_RCD`+`DONE_LAT` cycles. ACT commands are spaced at least `SLOT_CYC` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 4 | request valid, one bit per group |
| req_we | input | 4 | 1 = write, 0 = read, per group |
| req_row | input | 4*ROW_W | row per group, group g at bits [g*ROW_W +: ROW_W] |
| req_col | input | 4*COL_W | column per group, group g at bits [g*COL_W +: COL_W] |
| req_ready | output | 4 | slot-start ready, one bit per group |
| dram_cmd | output | 2 | 00 NOP, 01 ACT, 10 RD, 11 WR |
| dram_rank | output | 1 | rank select |
| dram_bank | output | BANK_W | bank select within the rank |
| dram_addr | output | max(ROW_W,COL_W) | row on ACT, column on RD/WR |
| dram_ap | output | 1 | auto-precharge flag |
| done | output | 4 | completion pulse per group |

## Verification
The bound checker watches these properties on every cycle: the one-hot ready and its cyclic order, the ACT after every taken request and the quiet slot after an idle one, and the exact `T_RCD` gap and matching rank/bank between ACT and column command. It also checks the silence of the bus fields on NOP, the spacing between ACTs, and the one-hot done. Only the bench's sweeps show the full values. These are the row and column on the address bus, the read/write choice, the rank and bank derived from the group, the exact done timing, and the reset state after a release in the middle of a slot. The sweeps cover every valid mask against every group over many rotations.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int NUM_GRP = 4;
  localparam int GRP_W   = 2;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } dram_cmd_e;
endpackage

// File: rtl/tts_slot_timer.sv
module tts_slot_timer #(
  parameter int SLOT_CYC = 4,
  parameter int PH_W     = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [PH_W-1:0]          phase,
  output logic [tts_pkg::GRP_W-1:0] grp,
  output logic                     slot_start
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      grp   <= '0;
    end else if (phase == LAST_PH) begin
      phase <= '0;
      grp   <= grp + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign slot_start = (phase == '0);
endmodule

// File: rtl/tts_cmd_gen.sv
module tts_cmd_gen #(
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14,
  parameter int T_RCD  = 2,
  parameter int PH_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PH_W-1:0]           phase,
  input  logic [tts_pkg::GRP_W-1:0] grp,
  input  logic                      slot_start,
  input  logic                      sel_valid,
  input  logic                      sel_we,
  input  logic [ROW_W-1:0]          sel_row,
  input  logic [COL_W-1:0]          sel_col,
  output tts_pkg::dram_cmd_e        cmd,
  output logic                      rank,
  output logic [BANK_W-1:0]         bank,
  output logic [ADDR_W-1:0]         addr,
  output logic                      ap,
  output logic                      col_fire,
  output logic [tts_pkg::GRP_W-1:0] col_grp
);
  import tts_pkg::*;

  localparam logic [PH_W-1:0] COL_PH = PH_W'(T_RCD);

  logic                 pend_q;
  logic                 we_q;
  logic [COL_W-1:0]     col_q;
  logic [GRP_W-1:0]     grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= CMD_NOP;
      rank     <= 1'b0;
      bank     <= '0;
      addr     <= '0;
      ap       <= 1'b0;
      col_fire <= 1'b0;
      col_grp  <= '0;
      pend_q   <= 1'b0;
      we_q     <= 1'b0;
      col_q    <= '0;
      grp_q    <= '0;
    end else begin
      cmd      <= CMD_NOP;
      rank     <= 1'b0;
      bank     <= '0;
      addr     <= '0;
      ap       <= 1'b0;
      col_fire <= 1'b0;
      if (slot_start && sel_valid) begin
        cmd    <= CMD_ACT;
        rank   <= grp[0];
        bank   <= BANK_W'(grp[1]);
        addr   <= ADDR_W'(sel_row);
        pend_q <= 1'b1;
        we_q   <= sel_we;
        col_q  <= sel_col;
        grp_q  <= grp;
      end else if (pend_q && (phase == COL_PH)) begin
        cmd      <= we_q ? CMD_WR : CMD_RD;
        rank     <= grp_q[0];
        bank     <= BANK_W'(grp_q[1]);
        addr     <= ADDR_W'(col_q);
        ap       <= 1'b1;
        col_fire <= 1'b1;
        col_grp  <= grp_q;
        pend_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tts_done_pipe.sv
module tts_done_pipe #(
  parameter int DONE_LAT = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fire,
  input  logic [tts_pkg::GRP_W-1:0]           fire_grp,
  output logic [tts_pkg::NUM_GRP-1:0]         done
);
  import tts_pkg::*;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    logic [DONE_LAT-1:0] sr;
    assign hit = fire && (fire_grp == GRP_W'(g));

    if (DONE_LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= hit;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DONE_LAT-2:0], hit};
      end
    end

    assign done[g] = sr[DONE_LAT-1];
  end
endmodule

// File: rtl/tt_bank_sched.sv
module tt_bank_sched #(
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int BANK_W   = 3,
  parameter int SLOT_CYC = 4,
  parameter int T_RCD    = 2,
  parameter int DONE_LAT = 3,
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           req_valid,
  input  logic [3:0]           req_we,
  input  logic [4*ROW_W-1:0]   req_row,
  input  logic [4*COL_W-1:0]   req_col,
  output logic [3:0]           req_ready,
  output logic [1:0]           dram_cmd,
  output logic                 dram_rank,
  output logic [BANK_W-1:0]    dram_bank,
  output logic [ADDR_W-1:0]    dram_addr,
  output logic                 dram_ap,
  output logic [3:0]           done
);
  import tts_pkg::*;

  localparam int PH_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [PH_W-1:0]  phase;
  logic [GRP_W-1:0] grp;
  logic             slot_start;
  logic             sel_valid;
  logic             sel_we;
  logic [ROW_W-1:0] sel_row;
  logic [COL_W-1:0] sel_col;
  dram_cmd_e        cmd;
  logic             col_fire;
  logic [GRP_W-1:0] col_grp;

  tts_slot_timer #(.SLOT_CYC(SLOT_CYC), .PH_W(PH_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .grp(grp), .slot_start(slot_start)
  );

  assign sel_valid = req_valid[grp];
  assign sel_we    = req_we[grp];
  assign sel_row   = req_row[grp*ROW_W +: ROW_W];
  assign sel_col   = req_col[grp*COL_W +: COL_W];
  assign req_ready = slot_start ? (4'b0001 << grp) : 4'b0000;

  tts_cmd_gen #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .T_RCD(T_RCD), .PH_W(PH_W)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .phase(phase), .grp(grp), .slot_start(slot_start),
    .sel_valid(sel_valid), .sel_we(sel_we), .sel_row(sel_row), .sel_col(sel_col),
    .cmd(cmd), .rank(dram_rank), .bank(dram_bank), .addr(dram_addr), .ap(dram_ap),
    .col_fire(col_fire), .col_grp(col_grp)
  );

  assign dram_cmd = cmd;

  tts_done_pipe #(.DONE_LAT(DONE_LAT)) u_done (
    .clk(clk), .rst_n(rst_n), .fire(col_fire), .fire_grp(col_grp), .done(done)
  );
endmodule

// File: rtl/tts_checker.sv
module tts_checker #(
  parameter int BANK_W   = 3,
  parameter int ADDR_W   = 14,
  parameter int SLOT_CYC = 4,
  parameter int T_RCD    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        req_valid,
  input logic [3:0]        req_ready,
  input logic [1:0]        dram_cmd,
  input logic              dram_rank,
  input logic [BANK_W-1:0] dram_bank,
  input logic [ADDR_W-1:0] dram_addr,
  input logic              dram_ap,
  input logic [3:0]        done
);
  logic [7:0]        since_act;
  logic              seen_act;
  logic              act_rank;
  logic [BANK_W-1:0] act_bank;
  logic              seen_rdy;
  logic [1:0]        last_rdy;
  logic [1:0]        acc_grp;
  logic [1:0]        rdy_idx;
  logic              is_col;
  logic [3:0]        next_rdy;

  always_comb begin
    rdy_idx = 2'd0;
    for (int i = 0; i < 4; i++) if (req_ready[i]) rdy_idx = 2'(i);
  end

  assign is_col   = (dram_cmd == 2'b10) || (dram_cmd == 2'b11);
  assign next_rdy = 4'b0001 << (last_rdy + 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '0;
      seen_act  <= 1'b0;
      act_rank  <= 1'b0;
      act_bank  <= '0;
      seen_rdy  <= 1'b0;
      last_rdy  <= '0;
      acc_grp   <= '0;
    end else begin
      if (dram_cmd == 2'b01) begin
        since_act <= 8'd1;
        seen_act  <= 1'b1;
        act_rank  <= dram_rank;
        act_bank  <= dram_bank;
      end else if (since_act != 8'hFF) begin
        since_act <= since_act + 8'd1;
      end
      if (|req_ready) begin
        seen_rdy <= 1'b1;
        last_rdy <= rdy_idx;
      end
      if (|(req_valid & req_ready)) acc_grp <= rdy_idx;
    end
  end

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready)); // R2
  AST_READY_ROTATE: assert property (@(posedge clk) disable iff (!rst_n) (seen_rdy && |req_ready) |-> (req_ready == next_rdy)); // R2
  AST_ACCEPT_ACT: assert property (@(posedge clk) disable iff (!rst_n) (|(req_valid & req_ready)) |=> (dram_cmd == 2'b01 && !dram_ap)); // R3
  AST_ACT_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (dram_cmd == 2'b01) |-> (dram_rank == acc_grp[0] && dram_bank == BANK_W'(acc_grp[1]))); // R3
  AST_COL_SPACING: assert property (@(posedge clk) disable iff (!rst_n) is_col |-> (seen_act && since_act == 8'(T_RCD) && dram_rank == act_rank && dram_bank == act_bank)); // R4
  AST_COL_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n) is_col |-> dram_ap); // R4
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (dram_cmd == 2'b00) |-> (!dram_rank && dram_bank == '0 && dram_addr == '0 && !dram_ap)); // R5
  AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (|req_ready && !(|(req_valid & req_ready))) |=> (dram_cmd == 2'b00)); // R6
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(done)); // R7
  AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n) (dram_cmd == 2'b01 && seen_act) |-> (since_act >= 8'(SLOT_CYC))); // R8
endmodule

bind tt_bank_sched tts_checker #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .SLOT_CYC(SLOT_CYC), .T_RCD(T_RCD)
) i_tts_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dram_cmd(dram_cmd), .dram_rank(dram_rank), .dram_bank(dram_bank),
  .dram_addr(dram_addr), .dram_ap(dram_ap), .done(done)
);

// File: tb/test_tt_bank_sched.sv
module test_tt_bank_sched;
  localparam int ROW_W = 6;
  localparam int COL_W = 4;
  localparam int BANK_W = 2;
  localparam int S = 4;
  localparam int TRCD = 2;
  localparam int DL = 3;
  localparam int ADDR_W = 6;
  localparam int BUS_W = 2 + 1 + BANK_W + ADDR_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req_valid = '0;
  logic [3:0] req_we = '0;
  logic [4*ROW_W-1:0] req_row = '0;
  logic [4*COL_W-1:0] req_col = '0;
  logic [3:0] req_ready;
  logic [1:0] dram_cmd;
  logic dram_rank;
  logic [BANK_W-1:0] dram_bank;
  logic [ADDR_W-1:0] dram_addr;
  logic dram_ap;
  logic [3:0] done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic acc_s [256];
  logic we_s [256];
  logic [ROW_W-1:0] row_s [256];
  logic [COL_W-1:0] col_s [256];

  always #10 clk = ~clk;

  tt_bank_sched #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .SLOT_CYC(S), .T_RCD(TRCD), .DONE_LAT(DL)
  ) i_tt_bank_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
    .dram_cmd(dram_cmd), .dram_rank(dram_rank), .dram_bank(dram_bank),
    .dram_addr(dram_addr), .dram_ap(dram_ap), .done(done)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [BUS_W-1:0] pack_bus(input logic [1:0] c, input logic r,
      input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a, input logic p);
    return {c, r, b, a, p};
  endfunction

  task automatic run_phase(input int nslots, input int seed);
    for (int i = 0; i < 256; i++) acc_s[i] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 bus in reset", 64'(pack_bus({dram_cmd}, dram_rank, dram_bank, dram_addr, dram_ap)), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int t = 0; t < nslots * S; t++) begin
      int s = t / S;
      int c = t % S;
      int g = s % 4;
      logic [3:0] vm = 4'((s * 5 + s / 4 + seed) % 16);
      logic [BUS_W-1:0] ebus = '0;
      logic [3:0] edone = '0;
      string rq_bus = "R5";
      int tt = t - 1 - TRCD - DL;

      // expected outputs at time t
      if (c == 1 && acc_s[s]) begin
        ebus = pack_bus(2'b01, g[0], BANK_W'(g / 2), ADDR_W'(row_s[s]), 1'b0);
        rq_bus = "R3";
      end else if (c == 1 + TRCD && acc_s[s]) begin
        ebus = pack_bus(we_s[s] ? 2'b11 : 2'b10, g[0], BANK_W'(g / 2), ADDR_W'(col_s[s]), 1'b1);
        rq_bus = "R4";
      end else if (!acc_s[s]) begin
        rq_bus = "R6";
      end
      if (t == 0) rq_bus = "R1";
      if (tt >= 0 && tt % S == 0 && acc_s[tt / S]) edone = 4'b0001 << ((tt / S) % 4);

      chk(t == 0 ? "R1 ready" : "R2 ready", 64'(req_ready), 64'(c == 0 ? (4'b0001 << g) : 4'b0000));
      chk(rq_bus, 64'(pack_bus(dram_cmd, dram_rank, dram_bank, dram_addr, dram_ap)), 64'(ebus));
      chk("R7/R8 done", 64'(done), 64'(edone));

      // drive inputs for cycle t
      req_valid = (c == 0) ? vm : ~vm;
      for (int k = 0; k < 4; k++) begin
        req_we[k] = ((s + k + seed) % 3) == 0;
        req_row[k*ROW_W +: ROW_W] = ROW_W'(s * 37 + k * 11 + c);
        req_col[k*COL_W +: COL_W] = COL_W'(s * 13 + k * 5 + c * 3);
      end
      if (c == 0) begin
        acc_s[s] = vm[g];
        we_s[s]  = req_we[g];
        row_s[s] = req_row[g*ROW_W +: ROW_W];
        col_s[s] = req_col[g*COL_W +: COL_W];
      end
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    run_phase(160, 0);
    // reset taken mid-slot with requests in flight
    @(posedge clk);
    #3;
    run_phase(48, 7);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule